// File: doc/BRIEF.md
# Divide-by-three by reciprocal multiplication

This unit takes an unsigned 8-bit dividend and returns its integer quotient by three. It does not use a general divider. It multiplies the dividend by the fixed reciprocal constant 171 and then drops the low nine bits of the product. The multiply has no generic multiplier behind it. The constant is split into the factors 9 and 19, so the whole product comes from three adders whose inputs are shifted copies made by wiring alone. The unit gives no remainder.

A parameter chooses between two variants. In the purely combinational one the quotient follows the dividend directly and the clock and reset pins have no effect. In the registered one the quotient passes through one output flop, and a synchronous active-high reset clears that flop. The result then appears one clock edge after the dividend is sampled.

Top module: `div3_recip`

## Requirements
- R1: For every dividend value 0 to 255 the quotient equals the dividend divided by three, with the fraction discarded.
- R2: The quotient is 7 bits wide. Dividend 255 gives 85, dividend 254 gives 84, dividend 0 gives 0, and no output exceeds 85.
- R3: The internal 16-bit product equals the dividend times 171 exactly for every input, so no overflow occurs. It is built from three adders: x plus x shifted left by 3, then the sum of that value shifted left by 4, the same value shifted left by 1, and the value itself.
- R4: Dividend 61 (binary 111101) gives 20 (binary 010100), and dividend 41 gives 13.
- R5: With REGISTERED = 1, the quotient of the dividend present at a rising clock edge appears on the output after that edge and stays there until the next edge.
- R6: With REGISTERED = 1, rst high at a rising edge sets the quotient to 0 after that edge, whatever the dividend is.
- R7: With REGISTERED = 0, the quotient depends only on the current dividend. The clock and rst have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| dividend | input | 8 | Unsigned value to divide by three |
| quotient | output | 7 | Integer quotient |

## Verification
The registered instance delivers each result one rising edge after its dividend is driven. The bench drives inputs on falling edges and pushes each expected value into a queue. A monitor pops the queue 1 ns after every rising edge, so every entry is compared exactly one edge after it was driven. That includes the entries that expect zero during reset. A second instance is built without the register. The bench checks it 1 ns after the same falling edge, in zero cycles, and keeps doing so while rst is high.

// File: rtl/div3_recip.sv
module div3_recip #(
  parameter int IN_W = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IN_W-1:0] dividend,
  output logic [IN_W-2:0] quotient
);
  localparam int Y_W    = IN_W + 4;
  localparam int PROD_W = IN_W + 8;
  localparam int SHIFT  = 9;
  localparam int OUT_W  = IN_W - 1;

  logic [Y_W-1:0]    times9;
  logic [PROD_W-1:0] prod;
  logic [OUT_W-1:0]  q_comb;

  assign times9 = {4'b0, dividend} + {1'b0, dividend, 3'b0};
  assign prod   = {times9, 4'b0} + {3'b0, times9, 1'b0} + {4'b0, times9};
  assign q_comb = prod[SHIFT +: OUT_W];

  generate
    if (REGISTERED) begin : g_reg
      logic [OUT_W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= q_comb;
      end
      assign quotient = q_r;
    end else begin : g_comb
      assign quotient = q_comb;
    end
  endgenerate
endmodule

module div3_recip_chk #(
  parameter int IN_W = 8,
  parameter bit REG = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [IN_W-1:0]   dividend,
  input logic [IN_W-2:0]   quotient,
  input logic [IN_W+7:0]   prod
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    int'(prod) == int'(dividend) * 171);

  p_max_r2: assert property (@(posedge clk) disable iff (rst)
    int'(quotient) <= ((1 << IN_W) - 1) / 3);

  generate
    if (REG) begin : g_reg
      p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> int'(quotient) == int'($past(dividend)) / 3);
      p_reset_clear_r6: assert property (@(posedge clk)
        rst |=> quotient == '0);
    end else begin : g_comb
      p_comb_r7: assert property (@(posedge clk)
        int'(quotient) == int'(dividend) / 3);
    end
  endgenerate
endmodule

bind div3_recip div3_recip_chk #(.IN_W(IN_W), .REG(REGISTERED)) u_chk (
  .clk(clk), .rst(rst), .dividend(dividend), .quotient(quotient), .prod(prod)
);

// File: tb/tb_div3_recip.sv
`timescale 1ns/1ps
module tb_div3_recip;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = 8'd0;
  logic [6:0] q_reg, q_cmb;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  div3_recip #(.IN_W(8), .REGISTERED(1'b1)) dut (
    .clk(clk), .rst(rst), .dividend(din), .quotient(q_reg));

  div3_recip #(.IN_W(8), .REGISTERED(1'b0)) dut_c (
    .clk(clk), .rst(rst), .dividend(din), .quotient(q_cmb));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int x, input bit r, input string tag);
    @(negedge clk);
    rst = r;
    din = 8'(x);
    exp_q.push_back(r ? 0 : x / 3);
    tag_q.push_back(tag);
    #1;
    check(r ? "R7 (rst ignored)" : "R7", int'(q_cmb), x / 3);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0)
      check(tag_q.pop_front(), int'(q_reg), exp_q.pop_front());
  end

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    drive(0, 1'b1, "R6 reset");
    drive(170, 1'b1, "R6 reset with dividend");
    drive(255, 1'b1, "R6 reset with dividend");
    for (int i = 0; i < 256; i++) begin
      string t;
      if (i == 61 || i == 41) t = "R4";
      else if (i == 0 || i == 254 || i == 255) t = "R2";
      else t = "R1";
      drive(i, 1'b0, t);
    end
    drive(61, 1'b0, "R4 61->20");
    drive(41, 1'b0, "R4 41->13");
    drive(255, 1'b0, "R5 latency");
    drive(200, 1'b1, "R6 mid-run reset");
    drive(3, 1'b0, "R5 after reset");
    drive(2, 1'b0, "R5");
    for (int i = 255; i >= 0; i -= 17) drive(i, 1'b0, "R1 descending");
    drive(254, 1'b0, "R2 254->84");
    drive(0, 1'b0, "R2 0->0");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule